// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between a processor's execute stage and a data memory that is one 32-bit word wide. It takes a base register value, a signed 16-bit displacement, store data and a two-bit operation code. From these it forms the byte address of the access. It drives the word index and the per-byte write strobes toward memory. When a load's data returns one cycle later, it picks the correct byte from that word and places it in the low bits of the result.

Bytes inside a word are numbered big-endian. Byte offset zero is the most significant lane. A word access whose address is not a multiple of four raises a misaligned flag and never reaches memory.

Read responses are tracked by a two-state machine. In `ST_IDLE` no load result is pending. The transition `issue_read` moves it to `ST_LOAD_RESP` at the edge where an aligned load is accepted. In `ST_LOAD_RESP` the load result is presented. From there `issue_read` keeps the machine in `ST_LOAD_RESP` when another load is accepted in the same cycle. The transition `drain` returns it to `ST_IDLE` when no new load is accepted. The edge that completes a reset also forces `ST_IDLE`.

Top module: `lsa_unit`

## Requirements
- R1: The byte address is `base` plus the sign-extended `offset`, and `mem_addr` carries bits 31:2 of that sum in the same cycle. Negative offsets are included.
- R2: When a request is valid, `req_op` selects the operation with this encoding: 2'b00 load word, 2'b01 store word, 2'b10 load byte, 2'b11 store byte. An aligned store word drives `mem_be` = 4'b1111 and `mem_wdata` = `store_data`.
- R3: A store byte raises exactly one strobe, chosen by address bits 1:0. The value 00 gives `mem_be` 4'b1000 (bits 31:24), 01 gives 4'b0100, 10 gives 4'b0010 and 11 gives 4'b0001. The other three bytes of the memory word keep their contents.
- R4: For a store byte, `mem_wdata` holds `store_data[7:0]` copied into all four byte lanes.
- R5: An aligned load word asserts `mem_rd` in the request cycle. In the following cycle, `load_valid` is 1 and `load_data` equals the full addressed memory word.
- R6: A load byte returns the selected big-endian byte in bits 7:0 of `load_data` one cycle after the request, with bit 7 copied into bits 31:8.
- R7: A word access (load or store) with nonzero address bits 1:0 sets `misaligned` in the request cycle. It forces `mem_be` to zero and `mem_rd` low, and no `load_valid` follows. Byte accesses never set `misaligned`.
- R8: While `req_valid` is low, `mem_be` is zero and `mem_rd` is low. After reset, `load_valid` is low.
- R9: A new request is accepted in the same cycle that an earlier load's result is presented. That result shows the memory contents as they were before the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 30 | Word index toward memory |
| mem_rd | output | 1 | Read request toward memory |
| mem_be | output | 4 | Byte write strobes, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data toward memory |
| mem_rdata | input | 32 | Word returned by memory one cycle after `mem_rd` |
| misaligned | output | 1 | Word access not on a 4-byte boundary |
| load_valid | output | 1 | `load_data` holds a load result |
| load_data | output | 32 | Aligned load result |

## Verification
A load's result presentation and the acceptance of the next request can fall in the same cycle. The bench issues a load word and then, in the very next cycle, a store word to the same location. It checks that the returned data still shows the old word and that the strobes of the store are correct in that cycle. A following load must then return the new word. A load word followed directly by a load byte checks that two responses can run back to back without a gap.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        OP_LW = 2'b00,
        OP_SW = 2'b01,
        OP_LB = 2'b10,
        OP_SB = 2'b11
    } mem_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
        eff_addr = base + off_ext;
    end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / 8,
    parameter int LANE_W = $clog2(BYTES)
) (
    input  logic              req_valid,
    input  mem_op_e           op,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] store_data,
    output logic [BYTES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    output logic              rd_en,
    output logic              misaligned
);
    logic             is_word;
    logic             word_ok;
    logic [BYTES-1:0] lane_hit;

    always_comb begin
        is_word    = (op == OP_LW) || (op == OP_SW);
        misaligned = req_valid && is_word && (lane != '0);
        word_ok    = req_valid && (lane == '0);
        rd_en      = (req_valid && op == OP_LB) || (word_ok && op == OP_LW);
        wdata      = (op == OP_SB) ? {BYTES{store_data[7:0]}} : store_data;
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // strobe bit g covers bits g*8+7:g*8; byte offset 0 is the top lane
        assign lane_hit[g] = (lane == LANE_W'(BYTES - 1 - g));
        assign be[g] = (word_ok && op == OP_SW) ||
                       (req_valid && op == OP_SB && lane_hit[g]);
    end

endmodule

// File: rtl/lsa_load_align.sv
module lsa_load_align
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / 8,
    parameter int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  mem_op_e           op,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);
    resp_state_e       state_q;
    resp_state_e       state_d;
    logic              byte_q;
    logic [LANE_W-1:0] lane_q;
    logic [7:0]        sel_byte;

    always_comb begin
        state_d = issue ? ST_LOAD_RESP : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= 1'b0;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (issue) begin
                byte_q <= (op == OP_LB);
                lane_q <= lane;
            end
        end
    end

    always_comb begin
        sel_byte = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (lane_q == LANE_W'(k)) sel_byte = mem_rdata[(BYTES-1-k)*8 +: 8];
        end
    end

    always_comb begin
        load_valid = 1'b0;
        load_data  = '0;
        unique case (state_q)
            ST_IDLE: begin
                load_valid = 1'b0;
            end
            ST_LOAD_RESP: begin
                load_valid = 1'b1;
                load_data  = byte_q ? {{(DATA_W-8){sel_byte[7]}}, sel_byte} : mem_rdata;
            end
            default: begin
                load_valid = 1'b0;
            end
        endcase
    end

    AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> load_valid); // R5
    AST_VALID_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_valid) |-> $past(issue)); // R5

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_op,
    input  logic [ADDR_W-1:0]        base,
    input  logic [OFF_W-1:0]         offset,
    input  logic [DATA_W-1:0]        store_data,
    output logic [ADDR_W-LANE_W-1:0] mem_addr,
    output logic                     mem_rd,
    output logic [BYTES-1:0]         mem_be,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     misaligned,
    output logic                     load_valid,
    output logic [DATA_W-1:0]        load_data
);
    logic [ADDR_W-1:0] eff_addr;
    logic [LANE_W-1:0] lane;
    mem_op_e           op;

    assign op       = mem_op_e'(req_op);
    assign lane     = eff_addr[LANE_W-1:0];
    assign mem_addr = eff_addr[ADDR_W-1:LANE_W];

    lsa_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base     (base),
        .offset   (offset),
        .eff_addr (eff_addr)
    );

    lsa_store_lane #(.DATA_W(DATA_W)) u_store (
        .req_valid  (req_valid),
        .op         (op),
        .lane       (lane),
        .store_data (store_data),
        .be         (mem_be),
        .wdata      (mem_wdata),
        .rd_en      (mem_rd),
        .misaligned (misaligned)
    );

    lsa_load_align #(.DATA_W(DATA_W)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (mem_rd),
        .op         (op),
        .lane       (lane),
        .mem_rdata  (mem_rdata),
        .load_valid (load_valid),
        .load_data  (load_data)
    );

    AST_SB_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |-> $countones(mem_be) == 1); // R3
    AST_SB_REPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |-> mem_wdata[DATA_W-1 -: 8] == store_data[7:0]); // R4
    AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> mem_be == '0); // R7
    AST_MISALIGN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |=> !load_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_be == '0 && !mem_rd)); // R8
    AST_LB_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |=>
        (load_data[DATA_W-1:8] == '0 || load_data[DATA_W-1:8] == '1)); // R6

endmodule

// File: tb/lsa_unit_bench.sv
`timescale 1ns/1ps
module lsa_unit_bench;
    import lsa_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic [29:0] mem_addr;
    logic        mem_rd;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        misaligned;
    logic        load_valid;
    logic [31:0] load_data;

    logic [31:0] mem [0:15];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    lsa_unit u_lsa_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base(base), .offset(offset), .store_data(store_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misaligned(misaligned),
        .load_valid(load_valid), .load_data(load_data)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
        for (int b = 0; b < 4; b++) begin
            if (mem_be[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input mem_op_e op, input logic [31:0] b, input logic [15:0] o,
                         input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base = b; offset = o; store_data = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #2;
    endtask

    task automatic read_word(input logic [31:0] addr, output logic [31:0] val);
        drive(OP_LW, addr, 16'h0000, '0);
        idle();
        val = load_data;
    endtask

    task automatic t_reset();
        chk("R8 load_valid in reset", {31'b0, load_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1; #2;
        chk("R8 be idle", {28'b0, mem_be}, 32'd0);
        chk("R8 rd idle", {31'b0, mem_rd}, 32'd0);
        chk("R8 load_valid after reset", {31'b0, load_valid}, 32'd0);
    endtask

    task automatic t_address();
        drive(OP_LB, 32'h0000_0100, 16'hFFFC, '0);
        chk("R1 negative offset", {2'b0, mem_addr}, 32'h3F);
        drive(OP_LB, 32'h0000_0010, 16'h0009, '0);
        chk("R1 positive offset", {2'b0, mem_addr}, 32'h6);
        idle();
    endtask

    task automatic t_load_word();
        drive(OP_LW, 32'h0, 16'h0008, '0);
        chk("R5 rd asserted", {31'b0, mem_rd}, 32'd1);
        chk("R7 aligned lw flag", {31'b0, misaligned}, 32'd0);
        idle();
        chk("R5 valid", {31'b0, load_valid}, 32'd1);
        chk("R5 data", load_data, 32'h807F12A5);
        idle();
        chk("R5 valid drops", {31'b0, load_valid}, 32'd0);
    endtask

    task automatic t_load_byte();
        logic [31:0] exp [4];
        exp[0] = 32'hFFFFFF80; exp[1] = 32'h0000007F;
        exp[2] = 32'h00000012; exp[3] = 32'hFFFFFFA5;
        for (int k = 0; k < 4; k++) begin
            drive(OP_LB, 32'h0000_0010, 16'hFFF8 + 16'(k), '0);
            idle();
            chk($sformatf("R6 lane %0d", k), load_data, exp[k]);
        end
    endtask

    task automatic t_store_byte();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            drive(OP_SB, 32'h0000_000C, 16'(k), 32'h1234_5600 | 32'(8'hA0 + k));
            chk($sformatf("R3 strobe lane %0d", k), {28'b0, mem_be}, 32'(4'b1000 >> k));
            chk($sformatf("R4 replicate lane %0d", k), mem_wdata, {4{8'(8'hA0 + k)}});
        end
        idle();
        read_word(32'h0C, v);
        chk("R3 all lanes written", v, 32'hA0A1A2A3);
        drive(OP_SB, 32'h0000_0012, 16'h0000, 32'hFFFF_FFC3);
        idle();
        read_word(32'h10, v);
        chk("R3 other bytes kept", v, 32'h5566C388);
    endtask

    task automatic t_store_word();
        logic [31:0] v;
        drive(OP_SW, 32'h0000_0014, 16'h0000, 32'hCAFEF00D);
        chk("R2 strobes", {28'b0, mem_be}, 32'hF);
        chk("R2 wdata", mem_wdata, 32'hCAFEF00D);
        idle();
        read_word(32'h14, v);
        chk("R2 readback", v, 32'hCAFEF00D);
    endtask

    task automatic t_misaligned();
        logic [31:0] v;
        drive(OP_SW, 32'h0000_0019, 16'h0000, 32'hDEADDEAD);
        chk("R7 sw flag", {31'b0, misaligned}, 32'd1);
        chk("R7 sw strobes", {28'b0, mem_be}, 32'd0);
        idle();
        read_word(32'h18, v);
        chk("R7 word untouched", v, 32'h01020304);
        drive(OP_LW, 32'h0000_001A, 16'h0000, '0);
        chk("R7 lw flag", {31'b0, misaligned}, 32'd1);
        chk("R7 lw no read", {31'b0, mem_rd}, 32'd0);
        idle();
        chk("R7 no load_valid", {31'b0, load_valid}, 32'd0);
        drive(OP_SB, 32'h0000_0019, 16'h0000, 32'h0);
        chk("R7 byte never flagged", {31'b0, misaligned}, 32'd0);
        drive(OP_LB, 32'h0000_0019, 16'h0000, 32'h0);
        chk("R7 lb never flagged", {31'b0, misaligned}, 32'd0);
        idle();
        chk("R7 lb after sb data", load_data, 32'h00000000);
    endtask

    task automatic t_overlap();
        drive(OP_LW, 32'h0000_001C, 16'h0000, '0);
        drive(OP_SW, 32'h0000_001C, 16'h0000, 32'h12345678);
        chk("R9 valid with new request", {31'b0, load_valid}, 32'd1);
        chk("R9 old data returned", load_data, 32'h0BADBEEF);
        chk("R9 store strobes same cycle", {28'b0, mem_be}, 32'hF);
        drive(OP_LW, 32'h0000_001C, 16'h0000, '0);
        drive(OP_LB, 32'h0000_001C, 16'h0003, '0);
        chk("R9 new word", load_data, 32'h12345678);
        idle();
        chk("R9 back-to-back byte", load_data, 32'h00000078);
        idle();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[2] = 32'h807F12A5; mem[3] = 32'h11223344; mem[4] = 32'h55667788;
        mem[6] = 32'h01020304; mem[7] = 32'h0BADBEEF;
        @(negedge clk); @(negedge clk);
        t_reset();
        t_address();
        t_load_word();
        t_load_byte();
        t_store_byte();
        t_store_word();
        t_misaligned();
        t_overlap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule